// File: doc/BRIEF.md
# Least-Loaded Copy Engine Allocator

This block hands out a small pool of physical copy engines to a larger set of virtual requesters. Each requester, named by an ID, asks for a channel and is bound to the enabled engine that currently has the fewest users. The binding is recorded in a per-requester table. Each engine keeps a count of its users.

The first user of an idle engine makes the block pulse a start-up strobe for that engine, which resets it and turns on its interrupt. When the last user of an engine leaves, the block pulses a flush request. It then stops taking new requests until that engine reports idle. Finally it pulses a shut-down strobe and turns the engine's interrupt off.

Requests arrive one at a time over a valid/ready handshake. Each accepted request produces one response on the following cycle.

Top module: `chan_alloc`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, every engine interrupt enable is 0, no strobe is active and every engine count is zero.
- R2: An allocate request (req_op = 0) that is accepted on a clock edge makes rsp_valid high for exactly the next cycle. rsp_eng then holds the enabled engine with the strictly lowest user count. On a tie, the lowest index wins.
- R3: If the granted engine had zero users, eng_init pulses for one cycle on that engine's bit, in the same cycle as the response. Its eng_irq_en bit goes to 1 and the count becomes exactly 1.
- R4: If the granted engine already had users, its count is only incremented, and no eng_init bit is raised.
- R5: A release request (req_op = 1) for a mapped requester answers with rsp_err = 0 and rsp_eng equal to the engine it was bound to. It clears the mapping and decrements that engine's count. If the count stays above zero, there is no flush.
- R6: A release that takes a count to zero pulses eng_flush on that engine in the response cycle. req_ready then stays 0 until that engine's eng_idle bit is 1; idle bits of other engines do not end the wait. On the edge after eng_idle is seen, eng_stop pulses on that engine, its eng_irq_en bit drops to 0, and req_ready returns to 1 in the same cycle.
- R7: An allocate request when no engine is enabled (eng_en all zero) responds with rsp_err = 1 and rsp_eng = 0, and changes no count, mapping or strobe.
- R8: Releasing a requester that has no mapping responds with rsp_err = 1 and rsp_eng = 0, and is otherwise ignored.
- R9: Allocating a requester that is already mapped responds with rsp_err = 1 and rsp_eng = 0, and leaves its existing binding and the counts unchanged.
- R10: The engine counts never exceed the number of requesters, and their sum never exceeds it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_id | input | $clog2(NREQ) | Requester ID |
| eng_en | input | NENG | Engines that may be granted |
| eng_idle | input | NENG | Engine idle indication, used after a flush |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Request was refused |
| rsp_eng | output | max(1,$clog2(NENG)) | Engine index granted or released |
| eng_init | output | NENG | One-cycle reset-and-enable strobe per engine |
| eng_flush | output | NENG | One-cycle flush request per engine |
| eng_stop | output | NENG | One-cycle clear-flags-and-disable strobe per engine |
| eng_irq_en | output | NENG | Interrupt enable level per engine |

## Verification
The bench first steers counts into ties, to check that the lowest index wins. A design that compared with less-or-equal would pick a higher engine in that case.

It then takes an engine back to zero users and holds its idle input low, while raising the idle inputs of the other engines. A design that watched the wrong idle bit, or any idle bit, would raise ready too early.

It also sends double allocations, releases of unmapped IDs, and allocations with every engine disabled. A design that mishandled these would leak counts or emit spurious init strobes, which shows up later as wrong grants.

Random traffic over changing enable masks is compared against a model of the counts and the bindings.

// File: rtl/chan_alloc.sv
`timescale 1ns/1ps
module chan_alloc #(
  parameter int NREQ = 32,
  parameter int NENG = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_op,
  input  logic [$clog2(NREQ)-1:0]                req_id,
  input  logic [NENG-1:0]                        eng_en,
  input  logic [NENG-1:0]                        eng_idle,
  output logic                                   rsp_valid,
  output logic                                   rsp_err,
  output logic [(NENG > 1 ? $clog2(NENG) : 1)-1:0] rsp_eng,
  output logic [NENG-1:0]                        eng_init,
  output logic [NENG-1:0]                        eng_flush,
  output logic [NENG-1:0]                        eng_stop,
  output logic [NENG-1:0]                        eng_irq_en
);
  localparam int IDW = $clog2(NREQ);
  localparam int EW  = NENG > 1 ? $clog2(NENG) : 1;
  localparam int CW  = $clog2(NREQ + 1);

  logic [NREQ-1:0]          map_v;
  logic [NREQ-1:0][EW-1:0]  map_e;
  logic [NENG-1:0][CW-1:0]  cnt;
  logic                     waiting;
  logic [EW-1:0]            wait_e;

  logic          best_ok;
  logic [EW-1:0] best_e;
  logic [CW-1:0] best_c;

  wire           acc   = req_valid && req_ready;
  wire           cur_v = map_v[req_id];
  wire [EW-1:0]  cur_e = map_e[req_id];

  assign req_ready = !waiting;

  always_comb begin
    best_ok = 1'b0;
    best_e  = '0;
    best_c  = '0;
    for (int e = 0; e < NENG; e++) begin
      if (eng_en[e] && (!best_ok || cnt[e] < best_c)) begin
        best_ok = 1'b1;
        best_e  = EW'(e);
        best_c  = cnt[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_v      <= '0;
      map_e      <= '0;
      cnt        <= '0;
      waiting    <= 1'b0;
      wait_e     <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_eng    <= '0;
      eng_init   <= '0;
      eng_flush  <= '0;
      eng_stop   <= '0;
      eng_irq_en <= '0;
    end else begin
      rsp_valid <= 1'b0;
      eng_init  <= '0;
      eng_flush <= '0;
      eng_stop  <= '0;
      if (waiting && eng_idle[wait_e]) begin
        waiting            <= 1'b0;
        eng_stop[wait_e]   <= 1'b1;
        eng_irq_en[wait_e] <= 1'b0;
      end
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_eng   <= '0;
        if (!req_op) begin
          if (!cur_v && best_ok) begin
            rsp_err        <= 1'b0;
            rsp_eng        <= best_e;
            map_v[req_id]  <= 1'b1;
            map_e[req_id]  <= best_e;
            if (cnt[best_e] == '0) begin
              cnt[best_e]        <= CW'(1);
              eng_init[best_e]   <= 1'b1;
              eng_irq_en[best_e] <= 1'b1;
            end else begin
              cnt[best_e] <= cnt[best_e] + CW'(1);
            end
          end
        end else if (cur_v) begin
          rsp_err       <= 1'b0;
          rsp_eng       <= cur_e;
          map_v[req_id] <= 1'b0;
          cnt[cur_e]    <= cnt[cur_e] - CW'(1);
          if (cnt[cur_e] == CW'(1)) begin
            eng_flush[cur_e] <= 1'b1;
            waiting          <= 1'b1;
            wait_e           <= cur_e;
          end
        end
      end
    end
  end

  logic unused_idw;
  assign unused_idw = ^IDW;
endmodule

// File: rtl/chan_alloc_chk.sv
`timescale 1ns/1ps
module chan_alloc_chk #(
  parameter int NREQ = 32,
  parameter int NENG = 3
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 req_valid,
  input logic                                 req_ready,
  input logic                                 rsp_valid,
  input logic                                 rsp_err,
  input logic [NENG-1:0]                      eng_init,
  input logic [NENG-1:0]                      eng_flush,
  input logic [NENG-1:0]                      eng_stop,
  input logic [NENG-1:0]                      eng_irq_en,
  input logic [NENG-1:0][$clog2(NREQ+1)-1:0]  cnt
);
  int total;
  always_comb begin
    total = 0;
    for (int e = 0; e < NENG; e++) total += int'(cnt[e]);
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_rsp_caused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));
  p_init_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_init));
  p_init_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_init) |-> ((eng_irq_en & eng_init) == eng_init));
  p_flush_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_flush) |-> !req_ready);
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_stop) |-> ((eng_irq_en & eng_stop) == '0));
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (eng_init == '0 && eng_flush == '0));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    total <= NREQ);
endmodule

bind chan_alloc chan_alloc_chk #(.NREQ(NREQ), .NENG(NENG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .eng_init(eng_init),
  .eng_flush(eng_flush), .eng_stop(eng_stop), .eng_irq_en(eng_irq_en),
  .cnt(cnt)
);

// File: tb/test_chan_alloc.sv
`timescale 1ns/1ps
module test_chan_alloc;
  localparam int NREQ = 32;
  localparam int NENG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_op = 1'b0;
  logic [4:0] req_id = '0;
  logic [NENG-1:0] eng_en = '1;
  logic [NENG-1:0] eng_idle = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [1:0] rsp_eng;
  logic [NENG-1:0] eng_init, eng_flush, eng_stop, eng_irq_en;

  int n_run = 0;
  int n_fail = 0;
  int mcnt[NENG];
  bit mv[NREQ];
  int me[NREQ];
  bit [NENG-1:0] mirq = '0;

  always #4 clk = ~clk;

  chan_alloc #(.NREQ(NREQ), .NENG(NENG)) i_chan_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_id(req_id), .eng_en(eng_en), .eng_idle(eng_idle),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_eng(rsp_eng),
    .eng_init(eng_init), .eng_flush(eng_flush), .eng_stop(eng_stop),
    .eng_irq_en(eng_irq_en)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick();
    int b = -1;
    for (int e = 0; e < NENG; e++)
      if (eng_en[e] && (b < 0 || mcnt[e] < mcnt[b])) b = e;
    return b;
  endfunction

  task automatic xact(bit op, int id);
    int e;
    bit err;
    bit [NENG-1:0] xi, xf;
    err = 1'b1; e = 0; xi = '0; xf = '0;
    if (!op) begin
      if (!mv[id] && pick() >= 0) begin
        err = 1'b0; e = pick();
        if (mcnt[e] == 0) begin xi[e] = 1'b1; mirq[e] = 1'b1; end
        mcnt[e]++; mv[id] = 1'b1; me[id] = e;
      end
    end else if (mv[id]) begin
      err = 1'b0; e = me[id]; mv[id] = 1'b0; mcnt[e]--;
      if (mcnt[e] == 0) xf[e] = 1'b1;
    end
    @(negedge clk);
    req_op = op; req_id = 5'(id); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
    chk(rsp_err == err, err ? (op ? "R8 err" : "R7/R9 err") : "R2/R5 err",
        int'(rsp_err), int'(err));
    chk(int'(rsp_eng) == e, op ? "R5 rsp_eng" : "R2 rsp_eng", int'(rsp_eng), e);
    chk(eng_init == xi, "R3/R4 eng_init", int'(eng_init), int'(xi));
    chk(eng_flush == xf, "R6 eng_flush", int'(eng_flush), int'(xf));
    chk(eng_irq_en == mirq, "R3 eng_irq_en", int'(eng_irq_en), int'(mirq));
    if (xf != '0) begin
      repeat (2) @(negedge clk);
      chk(req_ready == 1'b0, "R6 ready low while waiting", int'(req_ready), 0);
      eng_idle = ~xf;
      repeat (2) @(negedge clk);
      chk(req_ready == 1'b0, "R6 other idle ignored", int'(req_ready), 0);
      eng_idle = xf;
      @(negedge clk);
      eng_idle = '0;
      mirq[e] = 1'b0;
      chk(eng_stop == xf, "R6 eng_stop", int'(eng_stop), int'(xf));
      chk(eng_irq_en == mirq, "R6 irq off", int'(eng_irq_en), int'(mirq));
      chk(req_ready == 1'b1, "R6 ready back", int'(req_ready), 1);
      @(negedge clk);
      chk(eng_stop == '0, "R6 stop one cycle", int'(eng_stop), 0);
    end else begin
      @(negedge clk);
      chk(rsp_valid == 1'b0 && eng_init == '0, "R2/R3 one-cycle pulse",
          int'(rsp_valid) + int'(eng_init), 0);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    for (int e = 0; e < NENG; e++) mcnt[e] = 0;
    for (int i = 0; i < NREQ; i++) begin mv[i] = 1'b0; me[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake idle",
        int'(req_ready) * 2 + int'(rsp_valid), 2);
    chk(eng_irq_en == '0 && eng_init == '0 && eng_flush == '0 && eng_stop == '0,
        "R1 engine outputs", int'(eng_irq_en), 0);
    // R2 R3: empty pool, lowest index first
    xact(0, 0); xact(0, 1); xact(0, 2);
    // R4: tie at 1 user each -> engine 0
    xact(0, 3);
    // R5: release to nonzero
    xact(1, 3);
    // R6: release to zero on engine 1
    xact(1, 1);
    // R3: engine 1 again least loaded
    xact(0, 4);
    // R8 R9
    xact(1, 20);
    xact(0, 0);
    // R7
    eng_en = '0; xact(0, 5);
    eng_en = 3'b100; xact(0, 5);
    eng_en = '1;
    // random traffic
    seed = 42;
    void'($urandom(seed));
    for (int k = 0; k < 600; k++) begin
      if ($urandom % 16 == 0) eng_en = NENG'($urandom);
      if ($urandom % 8 == 0) eng_en = '1;
      xact($urandom % 2 == 1, int'($urandom % NREQ));
    end
    eng_en = '1;
    for (int i = 0; i < NREQ; i++) if (mv[i]) xact(1, i);
    chk(eng_irq_en == '0, "R10 all engines off at end", int'(eng_irq_en), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule